// File: doc/BRIEF.md
# Watchdog and Reset Controller

This block is a fixed-interval hardware watchdog running on a slow real-time clock (nominally 38.4 kHz). It does not depend on any watchdog inside the processor. Firmware must pulse a refresh strobe often enough. If it does not, the counter expires. The block then drives a half-period reset pulse to the processor core, followed by a fixed startup hold of several thousand clock cycles, and then releases the core so that it boots from its reset vector.

The same block also merges two active-low external reset pins into the one core reset. Each pin is resynchronised into the slow clock domain. A pin going low takes effect at once, and its release is seen two rising edges later. A sticky cause flag records that the most recent restart came from the watchdog. The flag survives the watchdog reset. Only a firmware clear request or the main reset pin removes it.

Top module: `wdrc_top`

## Requirements
- R1: Driving either `rst_main_n` or `rst_aux_n` low raises `core_rst` immediately, without waiting for a clock edge. After the last low pin returns high, `core_rst` stays high through one more rising edge and drops at the second one.
- R2: The watchdog counter restarts at every accepted refresh. Expiry happens on the `TIMEOUT_CYC`-th rising edge after the last restart. A refresh seen at most `TIMEOUT_CYC-1` edges after the last restart prevents expiry.
- R3: A refresh sampled on the same edge as expiry is ignored, and the expiry still takes place.
- R4: In the clock cycle that begins at the expiry edge, `core_rst` is high only while the clock is high (for half a period).
- R5: From the next rising edge, `core_rst` is held high for exactly `HOLD_CYC` cycles and is then released. The counter restarts from zero at the release edge.
- R6: `wd_flag` goes high at the expiry edge and stays high through the pulse and the hold.
- R7: `flag_clr` sampled high on an edge clears `wd_flag`. If expiry happens on the same edge, the flag stays high.
- R8: While `rst_main_n` is low, `wd_flag` is cleared. A low on `rst_aux_n` leaves the flag unchanged.
- R9: Either reset pin restarts the counter, so the next expiry comes `TIMEOUT_CYC` edges after the core reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow real-time clock |
| rst_main_n | input | 1 | Main external reset pin, active low; also clears the cause flag |
| rst_aux_n | input | 1 | Secondary external reset pin, active low |
| kick | input | 1 | Firmware refresh strobe, one cycle per refresh |
| flag_clr | input | 1 | Firmware request to clear the cause flag |
| core_rst | output | 1 | Reset to the processor core, active high |
| wd_flag | output | 1 | Sticky watchdog-expiry cause flag |

## Verification
Two pairs of events can land on the same edge. The first pair is expiry and refresh: the bench places a refresh exactly `TIMEOUT_CYC` edges after a restart and expects the reset sequence anyway. The second pair is expiry and flag clear: the clear request is lined up with the expiring edge, and the flag must read high afterwards. The half-period pulse is judged by sampling `core_rst` in both phases of the expiry cycle.

// File: rtl/wdrc_pkg.sv
`timescale 1ns/1ps
package wdrc_pkg;

    // Nominal 1.3 s at 38.4 kHz, and the startup hold after an expiry
    localparam int unsigned DEF_TIMEOUT = 49920;
    localparam int unsigned DEF_HOLD    = 4100;
    localparam int unsigned SYNC_STAGES = 2;

    typedef enum logic [1:0] {
        WS_RUN   = 2'd0,
        WS_PULSE = 2'd1,
        WS_HOLD  = 2'd2
    } wd_state_e;

    typedef struct packed {
        logic main;
        logic any;
    } rst_req_t;

    function automatic int unsigned cnt_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/wdrc_rst_sync.sv
`timescale 1ns/1ps
module wdrc_rst_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic pin_n,
    output logic rst_o
);
    logic [STAGES-1:0] shift_q;

    // asynchronous assertion, synchronous release
    always_ff @(posedge clk or negedge pin_n) begin
        if (!pin_n) shift_q <= '0;
        else        shift_q <= {shift_q[STAGES-2:0], 1'b1};
    end

    assign rst_o = ~shift_q[STAGES-1];
endmodule

// File: rtl/wdrc_timer.sv
`timescale 1ns/1ps
module wdrc_timer
    import wdrc_pkg::*;
#(
    parameter int unsigned TIMEOUT_CYC = DEF_TIMEOUT
) (
    input  logic clk,
    input  logic rst,
    input  logic busy,
    input  logic kick,
    output logic expire
);
    localparam int unsigned CW = cnt_width(TIMEOUT_CYC);
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

    logic [CW-1:0] cnt_q;

    assign expire = !rst && !busy && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || busy)  cnt_q <= '0;
        else if (expire)  cnt_q <= '0;   // a refresh on this edge loses
        else if (kick)    cnt_q <= '0;
        else              cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/wdrc_seq.sv
`timescale 1ns/1ps
module wdrc_seq
    import wdrc_pkg::*;
#(
    parameter int unsigned HOLD_CYC = DEF_HOLD
) (
    input  logic clk,
    input  logic rst,
    input  logic expire,
    output logic ovf_q,
    output logic hold
);
    localparam int unsigned HW = cnt_width(HOLD_CYC);
    localparam logic [HW-1:0] HLAST = HW'(HOLD_CYC - 1);

    wd_state_e     st_q;
    logic [HW-1:0] hcnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= WS_RUN;
            hcnt_q <= '0;
        end else begin
            unique case (st_q)
                WS_RUN:   if (expire) st_q <= WS_PULSE;
                WS_PULSE: begin
                    st_q   <= WS_HOLD;
                    hcnt_q <= '0;
                end
                WS_HOLD: begin
                    if (hcnt_q == HLAST) st_q <= WS_RUN;
                    else                 hcnt_q <= hcnt_q + 1'b1;
                end
                default:  st_q <= WS_RUN;
            endcase
        end
    end

    assign ovf_q = (st_q == WS_PULSE);
    assign hold  = (st_q == WS_HOLD);
endmodule

// File: rtl/wdrc_flag.sv
`timescale 1ns/1ps
module wdrc_flag (
    input  logic clk,
    input  logic main_rst,
    input  logic expire,
    input  logic clr,
    output logic flag_q
);
    always_ff @(posedge clk) begin
        if (main_rst)    flag_q <= 1'b0;
        else if (expire) flag_q <= 1'b1;   // expiry beats a clear request
        else if (clr)    flag_q <= 1'b0;
    end
endmodule

// File: rtl/wdrc_top.sv
`timescale 1ns/1ps
module wdrc_top
    import wdrc_pkg::*;
#(
    parameter int unsigned TIMEOUT_CYC = DEF_TIMEOUT,
    parameter int unsigned HOLD_CYC    = DEF_HOLD
) (
    input  logic clk,
    input  logic rst_main_n,
    input  logic rst_aux_n,
    input  logic kick,
    input  logic flag_clr,
    output logic core_rst,
    output logic wd_flag
);
    localparam int unsigned NSRC = 2;

    logic [NSRC-1:0] pins_n;
    logic [NSRC-1:0] src_rst;
    rst_req_t        req;
    logic            any_rst;
    logic            main_rst;
    logic            expire;
    logic            ovf_q;
    logic            hold;

    assign pins_n = {rst_aux_n, rst_main_n};

    for (genvar g = 0; g < NSRC; g++) begin : g_sync
        wdrc_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .pin_n (pins_n[g]),
            .rst_o (src_rst[g])
        );
    end

    assign req.main = src_rst[0];
    assign req.any  = |src_rst;
    assign main_rst = req.main;
    assign any_rst  = req.any;

    wdrc_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
        .clk    (clk),
        .rst    (any_rst),
        .busy   (ovf_q | hold),
        .kick   (kick),
        .expire (expire)
    );

    wdrc_seq #(.HOLD_CYC(HOLD_CYC)) u_seq (
        .clk    (clk),
        .rst    (any_rst),
        .expire (expire),
        .ovf_q  (ovf_q),
        .hold   (hold)
    );

    wdrc_flag u_flag (
        .clk      (clk),
        .main_rst (main_rst),
        .expire   (expire),
        .clr      (flag_clr),
        .flag_q   (wd_flag)
    );

    // the pulse is gated by the high phase of the clock in the expiry cycle
    assign core_rst = any_rst | hold | (ovf_q & clk);
endmodule

// File: rtl/wdrc_chk.sv
`timescale 1ns/1ps
module wdrc_chk (
    input logic clk,
    input logic any_rst,
    input logic main_rst,
    input logic expire,
    input logic kick,
    input logic flag_clr,
    input logic ovf_q,
    input logic hold,
    input logic wd_flag
);
    // R3
    kick_loses_chk: assert property (@(posedge clk) disable iff (any_rst)
        (expire && kick) |=> ovf_q);

    // R5
    hold_follows_chk: assert property (@(posedge clk) disable iff (any_rst)
        ovf_q |=> hold);

    // R2
    no_expire_busy_chk: assert property (@(posedge clk) disable iff (any_rst)
        (ovf_q || hold) |-> !expire);

    // R6
    flag_in_pulse_chk: assert property (@(posedge clk) disable iff (main_rst)
        ovf_q |-> wd_flag);

    // R7
    clr_priority_chk: assert property (@(posedge clk) disable iff (main_rst)
        (expire && flag_clr) |=> wd_flag);

    // R8
    main_clears_chk: assert property (@(posedge clk) disable iff (!main_rst)
        main_rst |=> !wd_flag);
endmodule

bind wdrc_top wdrc_chk u_chk (
    .clk      (clk),
    .any_rst  (any_rst),
    .main_rst (main_rst),
    .expire   (expire),
    .kick     (kick),
    .flag_clr (flag_clr),
    .ovf_q    (ovf_q),
    .hold     (hold),
    .wd_flag  (wd_flag)
);

// File: tb/wdrc_top_test.sv
`timescale 1ns/1ps
module wdrc_top_test;
    localparam int TB_T = 40;
    localparam int TB_H = 12;
    localparam int NV   = 7;
    // vector table: refresh gap in edges, and whether expiry is expected
    localparam int GAP [NV] = '{1, 5, TB_T-1, TB_T, TB_T/2, TB_T, TB_T-1};
    localparam bit OVF [NV] = '{0, 0, 0,      1,    0,      1,    0};

    logic clk = 1'b0;
    logic rst_main_n = 1'b0;
    logic rst_aux_n  = 1'b1;
    logic kick = 1'b0;
    logic flag_clr = 1'b0;
    logic core_rst;
    logic wd_flag;
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done = 1'b0;

    always #10 clk = ~clk;

    wdrc_top #(.TIMEOUT_CYC(TB_T), .HOLD_CYC(TB_H)) uut (
        .clk(clk), .rst_main_n(rst_main_n), .rst_aux_n(rst_aux_n),
        .kick(kick), .flag_clr(flag_clr), .core_rst(core_rst), .wd_flag(wd_flag)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // advance n rising edges; return 5 ns after the last one (clock high)
    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #5;
        end
    endtask

    // at the sample point just after the expiry edge: pulse, hold, release
    task automatic run_expiry(input string tag);
        chk({tag, " R4 pulse high phase"}, core_rst, 1'b1);
        chk({tag, " R6 flag set"}, wd_flag, 1'b1);
        #10;
        chk({tag, " R4 pulse low phase"}, core_rst, 1'b0);
        tick(TB_H);
        chk({tag, " R5 hold last cycle"}, core_rst, 1'b1);
        chk({tag, " R6 flag through hold"}, wd_flag, 1'b1);
        tick(1);
        chk({tag, " R5 released"}, core_rst, 1'b0);
    endtask

    initial begin
        tick(5);
        chk("R1 reset state core", core_rst, 1'b1);
        chk("R8 reset state flag", wd_flag, 1'b0);
        rst_main_n = 1'b1;
        tick(1);
        chk("R1 one edge after release", core_rst, 1'b1);
        tick(1);
        chk("R1 two edges after release", core_rst, 1'b0);

        // table walk, counter freshly restarted at this edge
        for (int v = 0; v < NV; v++) begin
            tick(GAP[v] - 1);
            kick = 1'b1;
            tick(1);
            kick = 1'b0;
            if (OVF[v]) begin
                run_expiry("R2 R3 table");
                kick = 1'b1; flag_clr = 1'b1;
                tick(1);
                kick = 1'b0; flag_clr = 1'b0;
                chk("R7 flag cleared", wd_flag, 1'b0);
            end else begin
                chk("R2 refresh in time", core_rst, 1'b0);
                chk("R2 flag stays low", wd_flag, 1'b0);
            end
        end

        // R7: clear request on the expiry edge
        tick(TB_T - 1);
        chk("R2 no early expiry", core_rst, 1'b0);
        flag_clr = 1'b1;
        tick(1);
        flag_clr = 1'b0;
        run_expiry("R7 clr vs expiry");

        // R8: secondary pin keeps the flag; R1 asynchronous assertion
        rst_aux_n = 1'b0;
        #1;
        chk("R1 aux async assert", core_rst, 1'b1);
        tick(2);
        chk("R8 aux keeps flag", wd_flag, 1'b1);
        rst_aux_n = 1'b1;
        tick(1);
        chk("R1 aux one edge after release", core_rst, 1'b1);
        tick(1);
        chk("R1 aux released", core_rst, 1'b0);

        // R9: counter restarted by the pin
        tick(TB_T - 1);
        chk("R9 no expiry before timeout", core_rst, 1'b0);
        tick(1);
        run_expiry("R9 restart");

        // R8: main pin clears the flag
        rst_main_n = 1'b0;
        #1;
        chk("R1 main async assert", core_rst, 1'b1);
        tick(2);
        chk("R8 main clears flag", wd_flag, 1'b0);
        rst_main_n = 1'b1;
        tick(2);
        chk("R1 main released", core_rst, 1'b0);
        chk("R8 flag low after main", wd_flag, 1'b0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(20 * 5000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule